// File: doc/BRIEF.md
# Modular Doubling Sieve Iteration Engine

This block runs one sieve work item to completion. It is given an odd prime modulus `p`, a starting residue `r` below `p` and an iteration ceiling `maxn`. On a start pulse it captures these values. It then applies one modular step per clock, replacing the residue with `(2r - 1) mod p`, while an iteration counter `n` advances from 1.

The run ends in one of three ways. The residue can reach zero. The residue can come back to the value it was loaded with. The counter can pass the ceiling. The engine then raises `done` for one cycle and reports the final count and a 2-bit code saying which exit was taken. A controller feeds work items through the start/busy/done handshake. It reads the count and code at any time after `done`, and both stay put until the next run completes.

Top module: `dbl_sieve_engine`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `n_o` and `code_o` are all zero.
- R2: A `start_i` pulse while idle captures `p_i`, `r_i` and `maxn_i` and raises `busy_o` on the next edge. A `start_i` pulse while busy has no effect on the running item or on its result.
- R3: Each busy cycle performs one full iteration: residue doubled, minus one, then reduced once by `p` when it is at least `p`, with `n` incremented. A run that ends with count `n` under code 2 finishes `n-1` cycles after the start edge. Under codes 0 or 1 it finishes `n` cycles after the start edge.
- R4: When `n` exceeds `maxn` before either early exit, the engine stops with code 0 and `n_o = maxn + 1`. The ceiling is tested before the zero test, so `maxn = 0` always gives code 0 with `n_o = 1`.
- R5: When the residue is zero at the top of an iteration, the engine stops with code 1 and reports the current `n`. A loaded residue of zero therefore gives `n_o = 1`.
- R6: When the residue after a step equals the loaded residue, the engine stops with code 2 and reports the incremented `n`. A loaded residue of 1 gives `n_o = 2`.
- R7: `done_o` is high for exactly one cycle, on the same edge at which `busy_o` falls.
- R8: `n_o` and `code_o` change only on the edge that raises `done_o` and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start_i | input | 1 | Single-cycle start pulse, honoured only while idle |
| p_i | input | W | Prime modulus, top bit clear |
| r_i | input | W | Starting residue, below `p_i` |
| maxn_i | input | NW | Iteration ceiling |
| busy_o | output | 1 | High while an item is running |
| done_o | output | 1 | One-cycle completion pulse |
| n_o | output | NW | Final iteration count |
| code_o | output | 2 | Exit code: 0 ceiling, 1 zero residue, 2 residue returned |

## Verification
An error in the step datapath changes the residue trajectory. The wrong value then shows up as a wrong count or a wrong exit code when the run ends. A missed reduction or a bad borrow usually pushes the residue above `p`, so it never returns. The run then falls through to code 0 at `maxn + 1` rather than exiting early. A counter or sequencing fault shows directly as a completion cycle that differs from the count reported. For that reason the bench checks the latency of every run as well as its result. A sweep over every residue of every small prime exposes a wrong trajectory within one run, because each residue's cycle length is fixed by the order of 2 modulo `p`.

// File: rtl/dbl_sieve_pkg.sv
package dbl_sieve_pkg;
  typedef enum logic [1:0] {
    RES_LIMIT = 2'd0,
    RES_ZERO  = 2'd1,
    RES_CYCLE = 2'd2
  } res_code_e;
endpackage

// File: rtl/dbl_sieve_step.sv
// One modular step: (2r - 1) reduced once by p. The reduce decision is the
// borrow of the trial subtraction, so no separate magnitude comparator.
module dbl_sieve_step #(
  parameter int W = 64
) (
  input  logic [W-1:0] r_i,
  input  logic [W-1:0] p_i,
  output logic [W-1:0] r_o
);
  logic [W-1:0] dbl;
  logic [W-1:0] dec;
  logic [W:0]   trial;

  always_comb begin
    dbl   = {r_i[W-2:0], 1'b0};
    dec   = dbl - {{(W-1){1'b0}}, 1'b1};
    trial = {1'b0, dec} - {1'b0, p_i};
    r_o   = trial[W] ? dec : trial[W-1:0];
  end
endmodule

// File: rtl/dbl_sieve_cnt.sv
// Iteration counter with the stored ceiling and the over-limit flag.
module dbl_sieve_cnt #(
  parameter int NW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          inc_i,
  input  logic [NW-1:0] maxn_i,
  output logic [NW-1:0] n_o,
  output logic [NW-1:0] n_inc_o,
  output logic          over_o
);
  logic [NW-1:0] n_q, n_d, maxn_q;

  always_comb begin
    n_inc_o = n_q + 1'b1;
    n_d     = n_q;
    if (load_i)     n_d = {{(NW-1){1'b0}}, 1'b1};
    else if (inc_i) n_d = n_inc_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q    <= '0;
      maxn_q <= '0;
    end else begin
      n_q <= n_d;
      if (load_i) maxn_q <= maxn_i;
    end
  end

  assign n_o    = n_q;
  assign over_o = (n_q > maxn_q);

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i && !load_i |=> n_q == $past(n_q) + 1'b1);
  assert_limit_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    over_o && !load_i && n_q != '0 |-> n_q == maxn_q + 1'b1);
endmodule

// File: rtl/dbl_sieve_engine.sv
module dbl_sieve_engine
  import dbl_sieve_pkg::*;
#(
  parameter int W  = 64,
  parameter int NW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [W-1:0]  p_i,
  input  logic [W-1:0]  r_i,
  input  logic [NW-1:0] maxn_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [NW-1:0] n_o,
  output logic [1:0]    code_o
);
  logic          busy_q, busy_d, done_q, done_d;
  logic [W-1:0]  p_q, init_q, r_q, r_d, step_r;
  logic [NW-1:0] res_q, res_d, n_cur, n_inc;
  res_code_e     code_q, code_d;
  logic          load, inc, over;

  dbl_sieve_step #(.W(W)) u_step (
    .r_i (r_q),
    .p_i (p_q),
    .r_o (step_r)
  );

  dbl_sieve_cnt #(.NW(NW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .inc_i   (inc),
    .maxn_i  (maxn_i),
    .n_o     (n_cur),
    .n_inc_o (n_inc),
    .over_o  (over)
  );

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    r_d    = r_q;
    res_d  = res_q;
    code_d = code_q;
    load   = 1'b0;
    inc    = 1'b0;
    if (!busy_q) begin
      if (start_i) begin
        load   = 1'b1;
        busy_d = 1'b1;
        r_d    = r_i;
      end
    end else if (over) begin
      busy_d = 1'b0;
      done_d = 1'b1;
      res_d  = n_cur;
      code_d = RES_LIMIT;
    end else if (r_q == '0) begin
      busy_d = 1'b0;
      done_d = 1'b1;
      res_d  = n_cur;
      code_d = RES_ZERO;
    end else begin
      inc = 1'b1;
      r_d = step_r;
      if (step_r == init_q) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        res_d  = n_inc;
        code_d = RES_CYCLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      r_q    <= '0;
      p_q    <= '0;
      init_q <= '0;
      res_q  <= '0;
      code_q <= RES_LIMIT;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      r_q    <= r_d;
      res_q  <= res_d;
      code_q <= code_d;
      if (load) begin
        p_q    <= p_i;
        init_q <= r_i;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign n_o    = res_q;
  assign code_o = code_q;

  assert_residue_below_p_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> r_q < p_q);
  assert_zero_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && code_q == RES_ZERO |-> r_q == '0);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_busy_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_d |=> $stable(res_q) && $stable(code_q));
endmodule

// File: tb/dbl_sieve_engine_tb.sv
module dbl_sieve_engine_tb;
  localparam int W  = 8;
  localparam int NW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [W-1:0]  p_i = '0, r_i = '0;
  logic [NW-1:0] maxn_i = '0;
  logic          busy_o, done_o;
  logic [NW-1:0] n_o;
  logic [1:0]    code_o;

  int vecs = 0;
  int errs = 0;
  bit hung = 1'b0;

  always #4 clk = ~clk;

  dbl_sieve_engine #(.W(W), .NW(NW)) u_dut (
    .clk (clk), .rst_n (rst_n), .start_i (start_i),
    .p_i (p_i), .r_i (r_i), .maxn_i (maxn_i),
    .busy_o (busy_o), .done_o (done_o), .n_o (n_o), .code_o (code_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected result computed arithmetically from the requirements.
  task automatic model(input int p, input int r, input int mx,
                       output int n, output int code);
    int cur;
    cur = r; n = 1; code = 0;
    forever begin
      if (n > mx) begin code = 0; break; end
      if (cur == 0) begin code = 1; break; end
      cur = 2 * cur - 1;
      if (cur >= p) cur = cur - p;
      n++;
      if (cur == r) begin code = 2; break; end
    end
  endtask

  // Runs one item; optionally pulses a conflicting start mid-run.
  task automatic run(input int p, input int r, input int mx, input bit poke);
    int en, ec, cyc, lat;
    model(p, r, mx, en, ec);
    @(negedge clk);
    start_i = 1'b1; p_i = W'(p); r_i = W'(r); maxn_i = NW'(mx);
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 busy after start", int'(busy_o), 1);
    cyc = 0;
    while (!done_o && !hung) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 2) begin
        start_i = 1'b1; p_i = 8'd5; r_i = 8'd0; maxn_i = 16'd3;
      end else begin
        start_i = 1'b0;
      end
      if (cyc > 4000) hung = 1'b1;
    end
    start_i = 1'b0;
    if (hung) begin
      chk("watchdog", 1, 0);
    end else begin
      lat = (ec == 2) ? en - 1 : en;
      chk("R3/R4/R5/R6 count", int'(n_o), en);
      chk("R4/R5/R6 code", int'(code_o), ec);
      chk("R3 latency", cyc, lat);
      chk("R7 busy low at done", int'(busy_o), 0);
      @(negedge clk);
      chk("R7 single pulse", int'(done_o), 0);
      chk("R8 count held", int'(n_o), en);
      chk("R8 code held", int'(code_o), ec);
    end
  endtask

  function automatic bit is_prime(input int v);
    if (v < 3) return 1'b0;
    for (int d = 2; d * d <= v; d++) if (v % d == 0) return 1'b0;
    return 1'b1;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 count", int'(n_o), 0);
    chk("R1 code", int'(code_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Corner cases named in the requirements.
    run(11, 0, 20, 1'b0);   // R5 zero at load: n = 1
    run(11, 1, 20, 1'b0);   // R6 fixed point: n = 2
    run(13, 0, 0, 1'b0);    // R4 ceiling tested first
    run(127, 3, 5, 1'b0);   // R4 ceiling hit mid-run
    run(127, 3, 60, 1'b1);  // R2 start while busy ignored

    // Sweep every residue of every odd prime below 128.
    for (int p = 3; p < 128 && !hung; p++) begin
      if (is_prime(p)) begin
        for (int r = 0; r < p && !hung; r++) run(p, r, 60, 1'b0);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule